// File: doc/BRIEF.md
# Packet Error and Loss Monitor

This block sits inside a receiver under test and measures how well packets get through, against a fixed test pattern that the transmitter sends over and over. Each packet carries a known run of 20 four-bit symbols. When synchronization succeeds, the monitor arms itself. It then compares the demodulated symbols, one by one and in order, with its own copy of the pattern. A packet with any wrong symbol adds one to an error count.

Beside the error count, the block keeps two more counters. One counts packet-start strobes from the stimulus side, the other counts sync-success pulses. The difference between them gives the packets lost before synchronization. All counters stop at full scale, and a synchronous clear input empties them together.

The comparison is run by a two-state machine. In `ST_IDLE` (disarmed), symbols are ignored; a sync pulse takes the transition *arm* to `ST_ARMED`. In `ST_ARMED`, each accepted symbol advances the index. The 20th symbol takes the transition *verdict* back to `ST_IDLE`, and counts the packet if it was bad. A further sync pulse takes the transition *rearm* (`ST_ARMED` to `ST_ARMED`), which drops the partial packet. The clear input takes the transition *flush* from either state to `ST_IDLE`.

Top module: `pkt_err_loss_mon`

## Requirements
- R1: An active-low asynchronous reset and a synchronous clear (`clr`) both set all counters to zero and disarm the comparator. While `clr` is high, strobes, sync pulses and symbols in that cycle have no effect.
- R2: `sent_cnt` goes up by one for every cycle in which `pkt_start` is high.
- R3: `sync_cnt` goes up by one for every cycle in which `sync_ok` is high, whether the comparator is armed or not.
- R4: `loss_cnt` equals `sent_cnt - sync_cnt` when `sent_cnt` is larger, and zero otherwise.
- R5: Only a `sync_ok` pulse arms the comparator. Symbols presented while it is disarmed are ignored. A packet start with no sync adds to loss only.
- R6: Reference symbol k (k = 0..19) is (5*k + 3) mod 16. The n-th symbol accepted after arming is compared with reference symbol n.
- R7: After the 20th accepted symbol, `err_cnt` rises by exactly one if any of the 20 symbols mismatched, however many did. It is unchanged if all 20 matched. The comparator then disarms.
- R8: A `sync_ok` while armed drops the partial packet without counting it and restarts at symbol 0. A symbol offered in the same cycle as that `sync_ok` is ignored.
- R9: Every counter holds at 65535 instead of wrapping.
- R10: Each counter changes at the rising clock edge that samples its event, and the new value is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all counters and the comparator |
| pkt_start | input | 1 | One strobe per transmitted test packet |
| sync_ok | input | 1 | Synchronization success pulse |
| sym_valid | input | 1 | A demodulated symbol is present on `sym_data` |
| sym_data | input | 4 | Demodulated symbol value |
| err_cnt | output | 16 | Errored packets, saturating |
| sync_cnt | output | 16 | Sync-success events, saturating |
| sent_cnt | output | 16 | Transmitted packets, saturating |
| loss_cnt | output | 16 | Sent minus synced, floored at zero |

## Verification
All three counters are registered, so each result is due one clock edge after the cycle that carries its event. The error count is due at the edge that samples the 20th symbol. `loss_cnt` is combinational from the registered counts, so it moves at the same edge as they do. The bench drives inputs on the falling edge and reads outputs on the next falling edge, after exactly one rising edge. One check also reads `sent_cnt` just before that rising edge, to confirm it has not moved early.

// File: rtl/pem_pkg.sv
package pem_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } pem_state_e;

endpackage

// File: rtl/pem_sat_cnt.sv
module pem_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pem_ref.sv
module pem_ref #(
    parameter int SYM_W   = 4,
    parameter int PKT_LEN = 20,
    parameter int REF_MUL = 5,
    parameter int REF_ADD = 3,
    parameter int IDX_W   = $clog2(PKT_LEN)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [SYM_W-1:0] ref_sym
);

    localparam int SYM_MOD = 2 ** SYM_W;

    logic [SYM_W-1:0] tbl [PKT_LEN];

    generate
        for (genvar k = 0; k < PKT_LEN; k++) begin : g_ref
            assign tbl[k] = SYM_W'((REF_MUL * k + REF_ADD) % SYM_MOD);
        end
    endgenerate

    always_comb begin
        if (idx < IDX_W'(PKT_LEN)) begin
            ref_sym = tbl[idx];
        end else begin
            ref_sym = '0;
        end
    end

endmodule

// File: rtl/pem_seq_fsm.sv
module pem_seq_fsm
    import pem_pkg::*;
#(
    parameter int SYM_W   = 4,
    parameter int PKT_LEN = 20,
    parameter int IDX_W   = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sync_ok,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic [SYM_W-1:0] ref_sym,
    output logic [IDX_W-1:0] sym_idx,
    output logic             pkt_bad
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    pem_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             mis_q, mis_d;
    logic             cur_mis;
    logic             at_last;

    assign cur_mis = (sym_data != ref_sym);
    assign at_last = (idx_q == LAST_IDX);
    assign sym_idx = idx_q;

    // next-state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        mis_d   = mis_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_ok) begin
                    state_d = ST_ARMED;   // arm
                    idx_d   = '0;
                    mis_d   = 1'b0;
                end
            end
            ST_ARMED: begin
                if (sync_ok) begin
                    state_d = ST_ARMED;   // rearm
                    idx_d   = '0;
                    mis_d   = 1'b0;
                end else if (sym_valid) begin
                    if (at_last) begin
                        state_d = ST_IDLE; // verdict
                        idx_d   = '0;
                        mis_d   = 1'b0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        mis_d = mis_q | cur_mis;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        pkt_bad = 1'b0;
        unique case (state_q)
            ST_IDLE:  pkt_bad = 1'b0;
            ST_ARMED: pkt_bad = !clr && !sync_ok && sym_valid && at_last
                                && (mis_q || cur_mis);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            mis_q   <= 1'b0;
        end else if (clr) begin
            state_q <= ST_IDLE;    // flush
            idx_q   <= '0;
            mis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            mis_q   <= mis_d;
        end
    end

endmodule

// File: rtl/pkt_err_loss_mon.sv
module pkt_err_loss_mon #(
    parameter int SYM_W   = 4,
    parameter int PKT_LEN = 20,
    parameter int CNT_W   = 16,
    parameter int REF_MUL = 5,
    parameter int REF_ADD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pkt_start,
    input  logic             sync_ok,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] sync_cnt,
    output logic [CNT_W-1:0] sent_cnt,
    output logic [CNT_W-1:0] loss_cnt
);

    localparam int IDX_W = $clog2(PKT_LEN);

    logic [IDX_W-1:0] sym_idx;
    logic [SYM_W-1:0] ref_sym;
    logic             pkt_bad;

    pem_ref #(
        .SYM_W  (SYM_W),
        .PKT_LEN(PKT_LEN),
        .REF_MUL(REF_MUL),
        .REF_ADD(REF_ADD),
        .IDX_W  (IDX_W)
    ) u_ref (
        .idx    (sym_idx),
        .ref_sym(ref_sym)
    );

    pem_seq_fsm #(
        .SYM_W  (SYM_W),
        .PKT_LEN(PKT_LEN),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sync_ok  (sync_ok),
        .sym_valid(sym_valid),
        .sym_data (sym_data),
        .ref_sym  (ref_sym),
        .sym_idx  (sym_idx),
        .pkt_bad  (pkt_bad)
    );

    pem_sat_cnt #(.W(CNT_W)) u_err_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(pkt_bad), .cnt(err_cnt)
    );

    pem_sat_cnt #(.W(CNT_W)) u_sync_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(sync_ok), .cnt(sync_cnt)
    );

    pem_sat_cnt #(.W(CNT_W)) u_sent_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(pkt_start), .cnt(sent_cnt)
    );

    assign loss_cnt = (sent_cnt > sync_cnt) ? (sent_cnt - sync_cnt) : '0;

endmodule

// File: rtl/pem_mon_chk.sv
module pem_mon_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             pkt_start,
    input logic             sync_ok,
    input logic             sym_valid,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] sync_cnt,
    input logic [CNT_W-1:0] sent_cnt,
    input logic [CNT_W-1:0] loss_cnt
);

    localparam logic [CNT_W-1:0] FULL = '1;

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_cnt == '0 && sync_cnt == '0 && sent_cnt == '0));

    a_r2_sent_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !pkt_start) |=> $stable(sent_cnt));

    a_r3_sync_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !sync_ok) |=> $stable(sync_cnt));

    a_r4_loss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        loss_cnt <= sent_cnt);

    a_r7_err_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

    a_r5_err_needs_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !sym_valid) |=> $stable(err_cnt));

    a_r9_sent_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && sent_cnt == FULL) |=> sent_cnt == FULL);

    a_r9_sync_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && sync_cnt == FULL) |=> sync_cnt == FULL);

endmodule

bind pkt_err_loss_mon pem_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .pkt_start(pkt_start),
    .sync_ok  (sync_ok),
    .sym_valid(sym_valid),
    .err_cnt  (err_cnt),
    .sync_cnt (sync_cnt),
    .sent_cnt (sent_cnt),
    .loss_cnt (loss_cnt)
);

// File: tb/pkt_err_loss_mon_tb.sv
module pkt_err_loss_mon_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam int ALL_BAD    = 30;
    localparam int NONE_BAD   = 31;

    // vector: {start, sync, nsym[4:0], badpos[4:0], err_inc}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 5'd20, 5'd31, 1'b0},  // clean packet
        {1'b1, 1'b1, 5'd20, 5'd0,  1'b1},  // first symbol wrong
        {1'b1, 1'b1, 5'd20, 5'd19, 1'b1},  // last symbol wrong
        {1'b1, 1'b0, 5'd20, 5'd31, 1'b0},  // no sync: lost, symbols ignored
        {1'b1, 1'b1, 5'd10, 5'd3,  1'b0},  // partial with error, left armed
        {1'b1, 1'b1, 5'd20, 5'd31, 1'b0},  // rearm drops partial, clean
        {1'b1, 1'b1, 5'd20, 5'd30, 1'b1},  // every symbol wrong, one count
        {1'b0, 1'b1, 5'd20, 5'd31, 1'b0}   // sync without start
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        pkt_start = 1'b0;
    logic        sync_ok = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  sym_data = '0;
    logic [15:0] err_cnt, sync_cnt, sent_cnt, loss_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_err = 0, exp_sync = 0, exp_sent = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_err_loss_mon u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pkt_start(pkt_start),
        .sync_ok(sync_ok), .sym_valid(sym_valid), .sym_data(sym_data),
        .err_cnt(err_cnt), .sync_cnt(sync_cnt), .sent_cnt(sent_cnt),
        .loss_cnt(loss_cnt)
    );

    function automatic logic [3:0] ref_of(input int k);
        return 4'((5 * k + 3) % 16);   // R6
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_syms(input int n, input int bad);
        for (int i = 0; i < n; i++) begin
            sym_valid = 1'b1;
            sym_data  = ref_of(i) ^ (((bad == ALL_BAD) || (bad == i)) ? 4'h8 : 4'h0);
            tick();
        end
        sym_valid = 1'b0;
    endtask

    task automatic check_all(input string req);
        int exp_loss;
        exp_loss = (exp_sent > exp_sync) ? exp_sent - exp_sync : 0;
        check({req, " err"},  int'(err_cnt),  exp_err);
        check({req, " sync"}, int'(sync_cnt), exp_sync);
        check({req, " sent"}, int'(sent_cnt), exp_sent);
        check({req, " loss R4"}, int'(loss_cnt), exp_loss);
    endtask

    initial begin
        repeat (200000 - 10000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check_all("R1 reset");
        rst_n = 1'b1;
        tick();

        // table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][12]) begin
                pkt_start = 1'b1; tick(); pkt_start = 1'b0;
                exp_sent++;
            end
            if (VEC[v][11]) begin
                sync_ok = 1'b1; tick(); sync_ok = 1'b0;
                exp_sync++;
            end
            send_syms(int'(VEC[v][10:6]), int'(VEC[v][5:1]));
            exp_err += int'(VEC[v][0]);
            check_all($sformatf("R7 vector %0d", v));
        end

        // R8: symbol in the same cycle as sync is ignored
        sync_ok = 1'b1; sym_valid = 1'b1; sym_data = ref_of(0) ^ 4'h8;
        tick();
        sync_ok = 1'b0; sym_valid = 1'b0;
        exp_sync++;
        send_syms(20, NONE_BAD);
        check_all("R8 same-cycle symbol");   // sync > sent: loss clamps

        // R10: sent_cnt moves only at the sampling edge
        pkt_start = 1'b1;
        #1 check("R10 before edge", int'(sent_cnt), exp_sent);
        tick();
        pkt_start = 1'b0;
        exp_sent++;
        check("R10 after edge", int'(sent_cnt), exp_sent);

        // R1: clear mid-packet with competing events, then disarmed (R5)
        sync_ok = 1'b1; tick(); sync_ok = 1'b0;
        send_syms(5, ALL_BAD);
        clr = 1'b1; pkt_start = 1'b1; sync_ok = 1'b1;
        tick();
        clr = 1'b0; pkt_start = 1'b0; sync_ok = 1'b0;
        exp_err = 0; exp_sync = 0; exp_sent = 0;
        send_syms(15, ALL_BAD);
        check_all("R1 clear priority");
        send_syms(20, ALL_BAD);
        check_all("R5 disarmed symbols");

        // R9: saturation of sent and sync
        pkt_start = 1'b1; sync_ok = 1'b1;
        repeat (65540) tick();
        pkt_start = 1'b0; sync_ok = 1'b0;
        check("R9 sent saturates", int'(sent_cnt), 65535);
        check("R9 sync saturates", int'(sync_cnt), 65535);
        check("R9 loss R4", int'(loss_cnt), 0);

        clr = 1'b1; tick(); clr = 1'b0;
        check("R1 clear after full", int'(sent_cnt), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule